// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Zeroing

This block turns the two phase signals of an incremental encoder into a signed position count. Both phase inputs pass through a short synchronizer. Every rising and falling transition on either phase then moves the count by one step, so the count has four times the resolution of the encoder's pulse rate. When A leads B the count rises. When B leads A it falls. If both phases change in the same sample, the change cannot be decoded and is discarded.

An index feature can force the count back to zero when a chosen line from a bank of digital inputs is high. A configuration write sets an enable flag and a line number. The index line is looked at only when an A or B transition is seen, never by itself. Software can also zero the count by writing a value of zero. The position output is a register, so during the cycle of that write it still shows the value from before the clear.

Top module: `quad_index_decoder`

## Requirements
- R1: Single-phase transitions in the forward Gray order (A,B) = 00, 10, 11, 01, 00 each raise the position by exactly one.
- R2: Single-phase transitions in the reverse order (00, 01, 11, 10, 00) each lower the position by exactly one.
- R3: A sample in which both A and B change leaves the position unchanged (unless the index rule R7 applies). A sample with no change also leaves it unchanged.
- R4: The position is a two's-complement value of POS_W bits (32 by default). It wraps from the most positive value to the most negative value when counting up, and from the most negative value to the most positive value when counting down.
- R5: A write with val_we high and val_wdata equal to zero clears the position one clock later. In the cycle of the write, position still shows the old value. A clear beats any transition that lands in the same cycle.
- R6: A write with a non-zero val_wdata has no effect on the position.
- R7: A configuration write stores cfg_data bit 15 as the index enable and cfg_data bits 4:0 as the index line number. When the index is enabled, any A/B transition (including a double change) that is seen while the selected z_lines bit is high sets the position to zero instead of stepping it.
- R8: The selected index line being high while no A/B transition occurs does not change the position.
- R9: With the index disabled, or with only an unselected z_lines bit high, transitions count normally.
- R10: After reset the position is zero and the index is disabled.
- R11: A change on enc_a or enc_b shows up on position three rising clock edges after it is applied (two synchronizer stages plus the count register). The z_lines inputs have the same delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| z_lines | input | Z_LINES (32) | Candidate index lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Configuration word: bit 15 index enable, bits 4:0 index line |
| val_we | input | 1 | Value write strobe |
| val_wdata | input | POS_W (32) | Value written; zero clears the position |
| position | output | POS_W (32) | Signed position count |

## Verification
The bench sweeps all sixteen (previous, next) phase pairs. This separates forward steps, reverse steps, double changes that must be discarded, and idle samples. Long runs in each direction use an 8-bit position so that both wrap points are crossed and the count is compared after every step. The index is exercised with the selected line high both with and without a transition, with an unselected line high, with the feature disabled, with the top line number, and together with a double change. This separates sampling the index on a transition from sampling it on every cycle. Clear writes are placed on an idle cycle, on the same cycle as a transition, and against non-zero writes. This separates the pre-clear output value, the clear's priority over a step, and the zero-only decode.

// File: rtl/qdec_pkg.sv
// Shared types for the quadrature decoder.
// Assumes at most 32 index candidates, so the line number fits in 5 bits.
package qdec_pkg;

    localparam int ZSEL_W     = 5;
    localparam int CFG_W      = 16;
    localparam int CFG_EN_BIT = 15;

    // Decoded movement of the phase pair for one sample
    typedef enum logic [1:0] {
        MOV_NONE = 2'd0,
        MOV_UP   = 2'd1,
        MOV_DN   = 2'd2,
        MOV_BAD  = 2'd3
    } move_e;

    // Stored index configuration
    typedef struct packed {
        logic              zen;
        logic [ZSEL_W-1:0] zsel;
    } idx_cfg_t;

endpackage

// File: rtl/qdec_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; gives STAGES cycles of delay.
module qdec_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the value along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/qdec_phase.sv
// Compares the synchronized phase pair with its previous sample and
// classifies the transition as up, down, none, or undecodable.
// Assumes inputs are already synchronous to clk.
module qdec_phase
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  a_s_i,
    input  logic  b_s_i,
    output move_e move_o
);

    logic a_q, b_q;
    logic a_chg, b_chg, fwd;

    // Hold the previous sample of both phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s_i;
            b_q <= b_s_i;
        end
    end

    // Classify the transition from the previous sample to the current one
    always_comb begin
        a_chg = a_s_i ^ a_q;
        b_chg = b_s_i ^ b_q;
        fwd   = (a_chg & (a_s_i ^ b_s_i)) | (b_chg & ~(a_s_i ^ b_s_i));
        unique case ({a_chg, b_chg})
            2'b00:   move_o = MOV_NONE;
            2'b11:   move_o = MOV_BAD;
            default: move_o = fwd ? MOV_UP : MOV_DN;
        endcase
    end

    // R3: a simultaneous change of both phases is never taken as a step
    assert_double_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_s_i != $past(a_s_i) && b_s_i != $past(b_s_i)) |-> move_o == MOV_BAD);

    // R3: a stable pair yields no movement
    assert_idle_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(a_s_i) && $stable(b_s_i)) |-> move_o == MOV_NONE);

endmodule

// File: rtl/qdec_index.sv
// Holds the index configuration and selects one candidate line.
// Assumes Z_LINES is at most 32 and the lines are already synchronized.
module qdec_index
    import qdec_pkg::*;
#(
    parameter int Z_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_data_i,
    input  logic [Z_LINES-1:0] z_s_i,
    output logic               z_hit_o
);

    localparam int PAD_W = 1 << ZSEL_W;

    idx_cfg_t         cfg_q;
    logic [PAD_W-1:0] z_pad;
    logic             cfg_unused;

    assign cfg_unused = &{1'b0, cfg_data_i[CFG_EN_BIT-1:ZSEL_W]};

    if (Z_LINES < PAD_W) begin : g_pad
        assign z_pad = {{(PAD_W-Z_LINES){1'b0}}, z_s_i};
    end else begin : g_full
        assign z_pad = z_s_i;
    end

    // Load enable and line number from the configuration word
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_we_i) cfg_q <= '{zen: cfg_data_i[CFG_EN_BIT], zsel: cfg_data_i[ZSEL_W-1:0]};
    end

    // Pick the selected line, gated by the enable
    always_comb z_hit_o = cfg_q.zen & z_pad[cfg_q.zsel];

    // R7: a configuration write is retained on the next cycle
    assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_q.zen == $past(cfg_data_i[CFG_EN_BIT]) &&
                      cfg_q.zsel == $past(cfg_data_i[ZSEL_W-1:0])));

    // R9: configuration holds between writes
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(cfg_q));

endmodule

// File: rtl/qdec_accum.sv
// Signed position register: clear, index zeroing, and up/down steps.
// Priority: software clear, then index on a transition, then step.
// Assumes inputs are synchronous; wraps in two's complement.
module qdec_accum
    import qdec_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  move_e            move_i,
    input  logic             z_hit_i,
    input  logic             clr_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q;
    logic             edge_seen;

    assign edge_seen = (move_i != MOV_NONE);

    // Update the position according to the priority order
    always_ff @(posedge clk) begin
        if (!rst_n)                    pos_q <= '0;
        else if (clr_i)                pos_q <= '0;
        else if (edge_seen && z_hit_i) pos_q <= '0;
        else if (move_i == MOV_UP)     pos_q <= pos_q + ONE;
        else if (move_i == MOV_DN)     pos_q <= pos_q - ONE;
    end

    assign pos_o = pos_q;

    // R1: an up step adds one
    assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (move_i == MOV_UP && !z_hit_i && !clr_i) |=> pos_q == $past(pos_q) + ONE);

    // R2: a down step subtracts one
    assert_step_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (move_i == MOV_DN && !z_hit_i && !clr_i) |=> pos_q == $past(pos_q) - ONE);

    // R5: a clear wins over anything in the same cycle
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> pos_q == '0);

    // R7: index on a transition zeroes the count
    assert_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && z_hit_i) |=> pos_q == '0);

    // R8: without a transition or clear the count holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move_i == MOV_NONE && !clr_i) |=> $stable(pos_q));

endmodule

// File: rtl/quad_index_decoder.sv
// Quadrature decoder top: synchronizes phases and index lines, decodes
// 4x transitions, applies index zeroing and software clear.
// Assumes Z_LINES <= 32 and asynchronous encoder inputs.
module quad_index_decoder
    import qdec_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int Z_LINES     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [Z_LINES-1:0] z_lines,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_data,
    input  logic               val_we,
    input  logic [POS_W-1:0]   val_wdata,
    output logic [POS_W-1:0]   position
);

    logic [1:0]         ab_s;
    logic [Z_LINES-1:0] z_s;
    move_e              move;
    logic               z_hit;
    logic               clr;

    qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ab (
        .clk(clk), .rst_n(rst_n), .d_i({enc_a, enc_b}), .q_o(ab_s)
    );

    qdec_sync #(.W(Z_LINES), .STAGES(SYNC_STAGES)) u_sync_z (
        .clk(clk), .rst_n(rst_n), .d_i(z_lines), .q_o(z_s)
    );

    qdec_phase u_phase (
        .clk(clk), .rst_n(rst_n), .a_s_i(ab_s[1]), .b_s_i(ab_s[0]), .move_o(move)
    );

    qdec_index #(.Z_LINES(Z_LINES)) u_index (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
        .z_s_i(z_s), .z_hit_o(z_hit)
    );

    // Only a write of zero requests a clear
    assign clr = val_we && (val_wdata == '0);

    qdec_accum #(.POS_W(POS_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .move_i(move), .z_hit_i(z_hit),
        .clr_i(clr), .pos_o(position)
    );

    // R6: a non-zero write never alters the count by itself
    assert_nonzero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && val_wdata != '0 && move == MOV_NONE) |=> $stable(position));

endmodule

// File: tb/quad_index_decoder_bench.sv
module quad_index_decoder_bench;

    localparam int PW = 8;
    localparam int ZL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enc_a = 1'b0;
    logic          enc_b = 1'b0;
    logic [ZL-1:0] z_lines = '0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_data = '0;
    logic          val_we = 1'b0;
    logic [PW-1:0] val_wdata = '0;
    logic [PW-1:0] position;

    int       total = 0;
    int       bad = 0;
    bit       done = 0;
    logic [PW-1:0] expv = '0;
    bit       zen_m = 0;
    int       zsel_m = 0;

    always #5 clk = ~clk;

    quad_index_decoder #(.POS_W(PW), .Z_LINES(ZL), .SYNC_STAGES(2)) u_quad_index_decoder (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .z_lines(z_lines),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .val_we(val_we), .val_wdata(val_wdata),
        .position(position)
    );

    function automatic int gidx(bit a, bit b);
        case ({a, b})
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] gbits(int i);
        case (i)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] ex);
        total++;
        if (act !== ex) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(ex));
        end
    endtask

    // Apply a new phase pair and check after three edges
    task automatic move_to(bit a, bit b);
        int    d;
        bit    chg;
        string tag;
        d   = (gidx(a, b) - gidx(enc_a, enc_b) + 4) % 4;
        chg = (a != enc_a) || (b != enc_b);
        enc_a = a;
        enc_b = b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (chg && zen_m && z_lines[zsel_m]) begin
            expv = '0; tag = "R7";
        end else if (d == 1) begin
            expv = expv + 1'b1; tag = "R1";
        end else if (d == 3) begin
            expv = expv - 1'b1; tag = "R2";
        end else begin
            tag = "R3";
        end
        chk(tag, position, expv);
    endtask

    task automatic fwd();
        logic [1:0] n;
        n = gbits((gidx(enc_a, enc_b) + 1) % 4);
        move_to(n[1], n[0]);
    endtask

    task automatic rev();
        logic [1:0] n;
        n = gbits((gidx(enc_a, enc_b) + 3) % 4);
        move_to(n[1], n[0]);
    endtask

    task automatic write_cfg(bit en, int sel);
        cfg_we   = 1'b1;
        cfg_data = {en, 10'b0, 5'(sel)};
        @(negedge clk);
        cfg_we = 1'b0;
        zen_m  = en;
        zsel_m = sel;
    endtask

    task automatic clear_pos();
        val_we    = 1'b1;
        val_wdata = '0;
        #1;
        chk("R5 pre-clear value", position, expv);
        @(negedge clk);
        val_we = 1'b0;
        expv   = '0;
        chk("R5 cleared", position, expv);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R10 reset value", position, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 after release", position, '0);

        // R11 latency: forward step from 00 to 10
        enc_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet", position, '0);
        @(posedge clk);
        @(negedge clk);
        expv = 8'd1;
        chk("R11 arrived", position, expv);

        // R1 R2 R3: all previous/next pairs
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic [1:0] pb, nb;
                pb = gbits(p);
                nb = gbits(n);
                move_to(pb[1], pb[0]);
                move_to(nb[1], nb[0]);
            end
        end

        // R4 upward wrap
        clear_pos();
        for (int i = 0; i < 127; i++) fwd();
        chk("R4 max", position, 8'h7F);
        fwd();
        chk("R4 wrap to min", position, 8'h80);

        // R4 downward wrap
        clear_pos();
        rev();
        chk("R4 minus one", position, 8'hFF);
        for (int i = 0; i < 127; i++) rev();
        chk("R4 min", position, 8'h80);
        rev();
        chk("R4 wrap to max", position, 8'h7F);

        // R6 non-zero writes ignored
        val_we = 1'b1; val_wdata = 8'd5;
        @(negedge clk);
        val_wdata = 8'h80;
        @(negedge clk);
        val_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 non-zero write", position, expv);

        // R5 clear coinciding with a transition
        begin
            logic [1:0] n;
            n = gbits((gidx(enc_a, enc_b) + 1) % 4);
            enc_a = n[1]; enc_b = n[0];
            repeat (2) @(posedge clk);
            @(negedge clk);
            val_we = 1'b1; val_wdata = '0;
            @(negedge clk);
            val_we = 1'b0;
            expv = '0;
            chk("R5 clear beats step", position, expv);
            repeat (3) @(negedge clk);
            chk("R5 step consumed", position, expv);
        end

        // Index behaviour
        write_cfg(1'b1, 7);
        fwd(); fwd(); fwd();
        z_lines[7] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 index without transition", position, expv);
        fwd();
        chk("R7 index zeroes", position, '0);
        z_lines[7] = 1'b0;
        fwd(); fwd();
        z_lines[3] = 1'b1;
        fwd();
        chk("R9 unselected line", position, 8'd3);
        z_lines[3] = 1'b0;
        rev();

        write_cfg(1'b1, 31);
        fwd(); fwd();
        z_lines[31] = 1'b1;
        rev();
        chk("R7 top line", position, '0);
        fwd(); fwd();
        z_lines[31] = 1'b0;
        fwd();
        z_lines[31] = 1'b1;
        begin
            logic [1:0] n;
            n = gbits((gidx(enc_a, enc_b) + 2) % 4);
            move_to(n[1], n[0]);
            chk("R7 double change with index", position, '0);
        end

        write_cfg(1'b0, 31);
        fwd(); fwd(); rev();
        chk("R9 index disabled", position, 8'd1);
        z_lines = '0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule